// File: doc/BRIEF.md
# Folded Symmetric Decimating FIR Engine

This block computes a decimating FIR filter with a single multiplier-accumulator. Input samples in signed 1.15 format arrive on a one-cycle strobe and are stored in a circular history memory. Every `rate_i + 1` samples a computation is due. The engine then steps through the coefficient entries, one per clock. For each entry a 17-bit pre-adder folds a newer-side sample and its mirrored older-side sample into one value. That value is multiplied by a signed 1.19 coefficient, and the product is accumulated at full precision in 43 bits (LSB weight 2^-34).

The folding mode is chosen per computation. It can add the two samples (even symmetry), subtract the older sample from the newer one (odd symmetry), or drop the older sample (non-symmetric). Odd-length filters feed the center sample alone. The accumulator feedback can be cut, so that only the last product reaches the output.

History keeps filling while the filter is disabled, so no start-up transient follows re-enabling. A computation that falls due while the previous one is still issuing taps is dropped and recorded in a sticky flag.

Top module: `fir_mac_engine`

## Requirements
- R1: While reset is asserted and right after it, `y_o` is 0, `y_vld_o` is 0 and `overrun_o` is 0.
- R2: With `sym_mode_i`=0, H=`half_taps_i` (1..8) and L=2H, a due sample x[n] gives `y_o` = sum over k=0..H-1 of c[k]*(x[n-k] + x[n-(L-1-k)]). Here x is the signed 16-bit integer, c is the signed 20-bit integer and `y_o` is the signed 43-bit exact sum.
- R3: With `sym_mode_i`=1 the pre-adder computes the newer sample minus the older one: c[k]*(x[n-k] - x[n-(L-1-k)]).
- R4: With `sym_mode_i`=2 or 3 the older operand is zero: `y_o` = sum of c[k]*x[n-k].
- R5: With `odd_len_i`=1, L=2H-1, and pair k=H-1 (the center) uses x[n-H+1] alone, with the older operand zero, in every mode.
- R6: A phase counter advances on every strobed sample, including while disabled. A computation is due on the sample at which the phase equals `rate_i`, after which the phase returns to 0. This gives one due sample in every `rate_i`+1, the first being sample `rate_i`+1 after reset.
- R7: No computation starts until 2H samples have been stored since reset, counting the due sample itself.
- R8: While `fir_en_i` is 0 no computation starts, but samples are still stored and phases still counted. After re-enabling, the results use the latest samples.
- R9: With `acc_clr_i`=1 the feedback is cut, and `y_o` equals the product of pair k=H-1 only.
- R10: `y_vld_o` is a one-cycle pulse after rising edge H+3, counting from the edge that stores the due sample. `y_o` changes only together with `y_vld_o`.
- R11: Taps are issued on the H edges that follow the start edge. If a computation falls due (enabled, filled) on one of those edges, it does not start, and `overrun_o` rises from that edge and holds until reset.
- R12: `coef_we_i` writes `coef_i` to entry `coef_addr_i`. Entry k multiplies the pair whose newer sample is x[n-k]. Entries survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smp_vld_i | input | 1 | Sample strobe, one sample per high cycle |
| smp_i | input | 16 | Sample, signed 1.15 |
| coef_we_i | input | 1 | Coefficient write enable |
| coef_addr_i | input | 3 | Coefficient entry index |
| coef_i | input | 20 | Coefficient, signed 1.19 |
| fir_en_i | input | 1 | Allows computations to start |
| half_taps_i | input | 4 | H, number of coefficient entries (1..8) |
| odd_len_i | input | 1 | Odd filter length 2H-1 |
| sym_mode_i | input | 2 | 0 add, 1 subtract, 2/3 older operand zero |
| rate_i | input | 4 | Decimation factor minus one |
| acc_clr_i | input | 1 | Cut accumulator feedback |
| y_o | output | 43 | Result, signed, LSB weight 2^-34 |
| y_vld_o | output | 1 | Result strobe |
| overrun_o | output | 1 | Sticky dropped-computation flag |

## Verification
Each result is due H+3 edges after the edge that stores its due sample. It appears on `y_vld_o` together with `y_o`, and H is known to the bench when it drives that sample. The bench numbers every rising edge, and when it drives a due sample it files the expected result under edge number (storing edge + H + 3). At each falling edge it compares the filed entry against the outputs, and it treats any pulse at an edge with nothing filed as an error. The overrun flag is compared after each run drains, against the first edge at which the bench model saw a due sample land inside the H-edge issue window.

// File: rtl/fir_pkg.sv
package fir_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned COEF_W = 20;
  localparam int unsigned PRE_W  = DATA_W + 1;
  localparam int unsigned PROD_W = PRE_W + COEF_W;
  localparam int unsigned GUARD_W = 6;
  localparam int unsigned ACC_W  = PROD_W + GUARD_W;

  typedef enum logic [1:0] {
    SYM_EVEN     = 2'd0,
    SYM_ODD      = 2'd1,
    SYM_NONE     = 2'd2,
    SYM_NONE_ALT = 2'd3
  } sym_mode_e;

  typedef struct packed {
    logic first;
    logic last;
    logic zero_old;
    logic sub;
    logic clr;
  } tap_ctl_t;
endpackage

// File: rtl/fir_data_mem.sv
module fir_data_mem import fir_pkg::*; #(
  parameter int unsigned DEPTH    = 32,
  parameter int unsigned TAPS_MAX = 16,
  parameter int unsigned HCNT_W   = 4,
  localparam int unsigned PTR_W   = $clog2(DEPTH),
  localparam int unsigned FILL_W  = $clog2(TAPS_MAX) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [HCNT_W-1:0] half_taps_i,
  input  logic [PTR_W-1:0]  rd_new_addr_i,
  input  logic [PTR_W-1:0]  rd_old_addr_i,
  output logic [PTR_W-1:0]  wp_o,
  output logic              fill_ok_o,
  output logic [DATA_W-1:0] rd_new_o,
  output logic [DATA_W-1:0] rd_old_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wp_q;
  logic [FILL_W-1:0] fill_q;
  logic [FILL_W:0]   fill_inc;
  logic [FILL_W:0]   fill_need;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q   <= '0;
      fill_q <= '0;
    end else if (we_i) begin
      wp_q <= wp_q + 1'b1;
      if (fill_q != FILL_W'(TAPS_MAX)) fill_q <= fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wp_q] <= wdata_i;
  end

  // history counts the sample being written in this cycle
  assign fill_inc  = {1'b0, fill_q} + (FILL_W+1)'(1);
  assign fill_need = (FILL_W+1)'({half_taps_i, 1'b0});
  assign fill_ok_o = fill_inc >= fill_need;

  assign wp_o     = wp_q;
  assign rd_new_o = mem_q[rd_new_addr_i];
  assign rd_old_o = mem_q[rd_old_addr_i];
endmodule

// File: rtl/fir_coef_mem.sv
module fir_coef_mem import fir_pkg::*; #(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned ADR_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADR_W-1:0]  waddr_i,
  input  logic [COEF_W-1:0] wdata_i,
  input  logic [ADR_W-1:0]  raddr_i,
  output logic [COEF_W-1:0] rdata_o
);
  logic [COEF_W-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/fir_seq.sv
module fir_seq import fir_pkg::*; #(
  parameter int unsigned HCNT_W = 4,
  parameter int unsigned PTR_W  = 5,
  parameter int unsigned RATE_W = 4,
  parameter int unsigned CADR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_vld_i,
  input  logic              fill_ok_i,
  input  logic              en_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [HCNT_W-1:0] half_taps_i,
  input  logic              odd_len_i,
  input  logic [1:0]        sym_mode_i,
  input  logic              acc_clr_i,
  input  logic [PTR_W-1:0]  wp_i,
  output logic              busy_o,
  output logic              iss_v_o,
  output tap_ctl_t          ctl_o,
  output logic [PTR_W-1:0]  rd_new_addr_o,
  output logic [PTR_W-1:0]  rd_old_addr_o,
  output logic [CADR_W-1:0] coef_addr_o,
  output logic              overrun_o
);
  logic [RATE_W-1:0] phase_q;
  logic              busy_q;
  logic [HCNT_W-1:0] k_q;
  logic [HCNT_W-1:0] h_q;
  logic [PTR_W-1:0]  base_q;
  logic              odd_q;
  logic              clr_q;
  sym_mode_e         mode_q;
  logic              ovr_q;

  logic              due, go, start, last;
  logic [HCNT_W:0]   span;

  assign due   = smp_vld_i && (phase_q == rate_i);
  assign go    = due && en_i && fill_ok_i;
  assign start = go && !busy_q;
  assign last  = (k_q == h_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      busy_q  <= 1'b0;
      k_q     <= '0;
      h_q     <= '0;
      base_q  <= '0;
      odd_q   <= 1'b0;
      clr_q   <= 1'b0;
      mode_q  <= SYM_EVEN;
      ovr_q   <= 1'b0;
    end else begin
      if (smp_vld_i) phase_q <= due ? '0 : phase_q + 1'b1;
      if (go && busy_q) ovr_q <= 1'b1;
      if (start) begin
        busy_q <= 1'b1;
        k_q    <= '0;
        base_q <= wp_i;
        h_q    <= half_taps_i;
        odd_q  <= odd_len_i;
        mode_q <= sym_mode_e'(sym_mode_i);
        clr_q  <= acc_clr_i;
      end else if (busy_q) begin
        if (last) busy_q <= 1'b0;
        else      k_q    <= k_q + 1'b1;
      end
    end
  end

  // span = filter length minus one
  assign span = odd_q ? ({h_q, 1'b0} - (HCNT_W+1)'(2))
                      : ({h_q, 1'b0} - (HCNT_W+1)'(1));

  assign rd_new_addr_o = base_q - PTR_W'(k_q);
  assign rd_old_addr_o = base_q - PTR_W'(span - {1'b0, k_q});
  assign coef_addr_o   = CADR_W'(k_q);

  assign ctl_o.first    = (k_q == '0);
  assign ctl_o.last     = last;
  assign ctl_o.zero_old = (mode_q == SYM_NONE) || (mode_q == SYM_NONE_ALT) || (odd_q && last);
  assign ctl_o.sub      = (mode_q == SYM_ODD);
  assign ctl_o.clr      = clr_q;

  assign busy_o    = busy_q;
  assign iss_v_o   = busy_q;
  assign overrun_o = ovr_q;
endmodule

// File: rtl/fir_mac.sv
module fir_mac import fir_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              iss_v_i,
  input  tap_ctl_t          ctl_i,
  input  logic [DATA_W-1:0] new_i,
  input  logic [DATA_W-1:0] old_i,
  input  logic [COEF_W-1:0] coef_i,
  output logic [ACC_W-1:0]  y_o,
  output logic              y_vld_o
);
  // stage 1: operand capture
  logic              v1_q, first1_q, last1_q, sub1_q, clr1_q;
  logic [DATA_W-1:0] a1_q, b1_q;
  logic [COEF_W-1:0] c1_q;
  // stage 2: pre-adder
  logic                     v2_q, first2_q, last2_q, clr2_q;
  logic signed [PRE_W-1:0]  pre2_q;
  logic signed [COEF_W-1:0] c2_q;
  // stage 3: multiplier
  logic                     v3_q, first3_q, last3_q, clr3_q;
  logic signed [PROD_W-1:0] prod3_q;
  // stage 4: accumulator
  logic [ACC_W-1:0] acc_q, y_q, prod_x, sum;
  logic             y_vld_q;

  logic [PRE_W-1:0] a_x, b_x;
  assign a_x = {a1_q[DATA_W-1], a1_q};
  assign b_x = {b1_q[DATA_W-1], b1_q};

  assign prod_x = {{GUARD_W{prod3_q[PROD_W-1]}}, prod3_q};
  assign sum    = (first3_q || clr3_q) ? prod_x : acc_q + prod_x;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0; first1_q <= 1'b0; last1_q <= 1'b0; sub1_q <= 1'b0; clr1_q <= 1'b0;
      a1_q <= '0; b1_q <= '0; c1_q <= '0;
      v2_q <= 1'b0; first2_q <= 1'b0; last2_q <= 1'b0; clr2_q <= 1'b0;
      pre2_q <= '0; c2_q <= '0;
      v3_q <= 1'b0; first3_q <= 1'b0; last3_q <= 1'b0; clr3_q <= 1'b0;
      prod3_q <= '0;
      acc_q <= '0; y_q <= '0; y_vld_q <= 1'b0;
    end else begin
      v1_q     <= iss_v_i;
      first1_q <= ctl_i.first;
      last1_q  <= ctl_i.last;
      sub1_q   <= ctl_i.sub;
      clr1_q   <= ctl_i.clr;
      a1_q     <= new_i;
      b1_q     <= ctl_i.zero_old ? '0 : old_i;
      c1_q     <= coef_i;

      v2_q     <= v1_q;
      first2_q <= first1_q;
      last2_q  <= last1_q;
      clr2_q   <= clr1_q;
      pre2_q   <= sub1_q ? (a_x - b_x) : (a_x + b_x);
      c2_q     <= c1_q;

      v3_q     <= v2_q;
      first3_q <= first2_q;
      last3_q  <= last2_q;
      clr3_q   <= clr2_q;
      prod3_q  <= pre2_q * c2_q;

      y_vld_q <= v3_q && last3_q;
      if (v3_q) begin
        acc_q <= sum;
        if (last3_q) y_q <= sum;
      end
    end
  end

  assign y_o     = y_q;
  assign y_vld_o = y_vld_q;
endmodule

// File: rtl/fir_mac_engine.sv
module fir_mac_engine import fir_pkg::*; #(
  parameter int unsigned HALF_MAX  = 8,
  parameter int unsigned RATE_W    = 4,
  localparam int unsigned TAPS_MAX = 2 * HALF_MAX,
  localparam int unsigned DEPTH    = 2 * TAPS_MAX,
  localparam int unsigned PTR_W    = $clog2(DEPTH),
  localparam int unsigned HCNT_W   = $clog2(HALF_MAX) + 1,
  localparam int unsigned CADR_W   = $clog2(HALF_MAX)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_vld_i,
  input  logic [DATA_W-1:0] smp_i,
  input  logic              coef_we_i,
  input  logic [CADR_W-1:0] coef_addr_i,
  input  logic [COEF_W-1:0] coef_i,
  input  logic              fir_en_i,
  input  logic [HCNT_W-1:0] half_taps_i,
  input  logic              odd_len_i,
  input  logic [1:0]        sym_mode_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              acc_clr_i,
  output logic [ACC_W-1:0]  y_o,
  output logic              y_vld_o,
  output logic              overrun_o
);
  logic [PTR_W-1:0]  wp;
  logic              fill_ok;
  logic [PTR_W-1:0]  rd_new_addr, rd_old_addr;
  logic [DATA_W-1:0] rd_new, rd_old;
  logic [CADR_W-1:0] coef_raddr;
  logic [COEF_W-1:0] coef_rd;
  logic              seq_busy, iss_v;
  tap_ctl_t          tap_ctl;

  fir_data_mem #(.DEPTH(DEPTH), .TAPS_MAX(TAPS_MAX), .HCNT_W(HCNT_W)) u_dmem (
    .clk_i, .rst_ni,
    .we_i(smp_vld_i), .wdata_i(smp_i), .half_taps_i,
    .rd_new_addr_i(rd_new_addr), .rd_old_addr_i(rd_old_addr),
    .wp_o(wp), .fill_ok_o(fill_ok),
    .rd_new_o(rd_new), .rd_old_o(rd_old)
  );

  fir_coef_mem #(.ENTRIES(HALF_MAX)) u_cmem (
    .clk_i, .we_i(coef_we_i), .waddr_i(coef_addr_i), .wdata_i(coef_i),
    .raddr_i(coef_raddr), .rdata_o(coef_rd)
  );

  fir_seq #(.HCNT_W(HCNT_W), .PTR_W(PTR_W), .RATE_W(RATE_W), .CADR_W(CADR_W)) u_seq (
    .clk_i, .rst_ni, .smp_vld_i, .fill_ok_i(fill_ok), .en_i(fir_en_i),
    .rate_i, .half_taps_i, .odd_len_i, .sym_mode_i, .acc_clr_i, .wp_i(wp),
    .busy_o(seq_busy), .iss_v_o(iss_v), .ctl_o(tap_ctl),
    .rd_new_addr_o(rd_new_addr), .rd_old_addr_o(rd_old_addr),
    .coef_addr_o(coef_raddr), .overrun_o
  );

  fir_mac u_mac (
    .clk_i, .rst_ni, .iss_v_i(iss_v), .ctl_i(tap_ctl),
    .new_i(rd_new), .old_i(rd_old), .coef_i(coef_rd),
    .y_o, .y_vld_o
  );
endmodule

// File: rtl/fir_mac_engine_chk.sv
module fir_mac_engine_chk import fir_pkg::*; (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             smp_vld_i,
  input logic             fir_en_i,
  input logic             y_vld_o,
  input logic             overrun_o,
  input logic [ACC_W-1:0] y_o,
  input logic             busy_i
);
  p_vld_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_vld_o |=> !y_vld_o);

  p_vld_after_issue_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_vld_o |-> $past(busy_i, 4));

  p_y_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !y_vld_o |-> $stable(y_o));

  p_ovr_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);

  p_ovr_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(smp_vld_i && busy_i));

  p_start_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(smp_vld_i && fir_en_i));
endmodule

bind fir_mac_engine fir_mac_engine_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .smp_vld_i(smp_vld_i), .fir_en_i(fir_en_i),
  .y_vld_o(y_vld_o), .overrun_o(overrun_o), .y_o(y_o), .busy_i(seq_busy)
);

// File: tb/tb_fir_mac_engine.sv
`timescale 1ns/1ps
module tb_fir_mac_engine;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        smp_vld_i = 1'b0, coef_we_i = 1'b0, fir_en_i = 1'b0;
  logic [15:0] smp_i = '0;
  logic [2:0]  coef_addr_i = '0;
  logic [19:0] coef_i = '0;
  logic [3:0]  half_taps_i = 4'd1, rate_i = '0;
  logic        odd_len_i = 1'b0, acc_clr_i = 1'b0;
  logic [1:0]  sym_mode_i = '0;
  logic [42:0] y_o;
  logic        y_vld_o, overrun_o;

  fir_mac_engine dut (.*);

  always #2 clk_i = ~clk_i;

  int checks = 0, errors = 0, cyc = 0, vld_seen = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  // bench model state
  int h = 1, odd = 0, mode = 0, rate = 0, clr = 0, en = 0;
  longint coef_m [8];
  longint hist [4096];
  int ns, fill, phase, busy_end, ovr_edge;
  int exp_cyc [512];
  longint exp_val [512];
  string exp_tag [512];
  int head = 0, tail = 0;
  string cur_tag = "R2";

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, expv, $time);
    end
  endtask

  function automatic longint ref_y(input int n);
    int len = odd ? 2*h-1 : 2*h;
    longint acc = 0, a, b, p, pr;
    for (int k = 0; k < h; k++) begin
      a = hist[n-k];
      b = (mode >= 2 || (odd != 0 && k == h-1)) ? 64'sd0 : hist[n-(len-1-k)];
      p = (mode == 1) ? a - b : a + b;
      pr = p * coef_m[k];
      acc = (clr != 0) ? pr : acc + pr;
    end
    return acc;
  endfunction

  // result monitor away from the active edge
  always @(negedge clk_i) if (rst_ni) begin
    if (y_vld_o) vld_seen++;
    if (head != tail && cyc == exp_cyc[head]) begin
      check(y_vld_o === 1'b1 && longint'($signed(y_o)) == exp_val[head],
            {exp_tag[head], " R10 result at due edge"}, longint'($signed(y_o)), exp_val[head]);
      head++;
    end else if (y_vld_o) begin
      check(1'b0, "R10 (R6 R7 R8) unexpected result", longint'($signed(y_o)), 0);
    end
  end

  task automatic apply_cfg();
    half_taps_i = 4'(h); odd_len_i = 1'(odd); sym_mode_i = 2'(mode);
    rate_i = 4'(rate); acc_clr_i = 1'(clr); fir_en_i = 1'(en);
  endtask

  // R12: coefficient entries written through the port
  task automatic load_coefs(input int mag);
    for (int k = 0; k < 8; k++) begin
      longint v;
      if (mag == 0) v = longint'($urandom_range(0, (1<<20)-1)) - (1<<19);
      else v = (k % 2 == 0) ? -(64'sd1 << 19) : 64'sd524287;
      coef_we_i = 1'b1; coef_addr_i = 3'(k); coef_i = 20'(v); coef_m[k] = v;
      @(negedge clk_i);
    end
    coef_we_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    ns = 0; fill = 0; phase = 0; busy_end = -100; ovr_edge = -1;
    head = 0; tail = 0; vld_seen = 0;
  endtask

  // called at a falling edge; returns at a falling edge
  task automatic send(input int val, input int gap);
    int c; bit due;
    smp_vld_i = 1'b1; smp_i = 16'(val);
    c = cyc + 1;
    hist[ns] = longint'(val); ns++;
    if (fill < 16) fill++;
    due = (phase == rate);
    phase = due ? 0 : ((phase + 1) & 15);
    if (due && en != 0 && fill >= 2*h) begin
      if (c <= busy_end) begin
        if (ovr_edge < 0) ovr_edge = c;
      end else begin
        busy_end = c + h;
        exp_cyc[tail] = c + h + 3; exp_val[tail] = ref_y(ns-1); exp_tag[tail] = cur_tag;
        tail++;
      end
    end
    @(negedge clk_i);
    smp_vld_i = 1'b0;
    repeat (gap) @(negedge clk_i);
  endtask

  function automatic int rnd_smp();
    return int'($urandom_range(0, 65535)) - 32768;
  endfunction

  task automatic drain_and_check();
    repeat (h + 8) @(negedge clk_i);
    check(head == tail, "R10 all due results seen", longint'(tail - head), 0);
    check(overrun_o === (ovr_edge >= 0), "R11 overrun flag", longint'(overrun_o), longint'(ovr_edge >= 0));
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (2) @(negedge clk_i);
    check(y_vld_o === 1'b0, "R1 y_vld_o in reset", longint'(y_vld_o), 0);
    check(y_o === '0, "R1 y_o in reset", longint'(y_o), 0);
    check(overrun_o === 1'b0, "R1 overrun_o in reset", longint'(overrun_o), 0);

    // R7 + R2: fill boundary, full-scale operands
    load_coefs(1);
    h = 2; odd = 0; mode = 0; rate = 0; clr = 0; en = 1; apply_cfg();
    do_reset();
    check(y_vld_o === 1'b0 && overrun_o === 1'b0, "R1 after reset", longint'(y_vld_o), 0);
    for (int i = 0; i < 3; i++) send(-32768, 0);
    repeat (8) @(negedge clk_i);
    check(vld_seen == 0, "R7 no result before 2H samples", longint'(vld_seen), 0);
    cur_tag = "R7 R2";
    send(-32768, 8);
    cur_tag = "R2";
    for (int i = 0; i < 6; i++) send((i % 2) ? 32767 : -32768, 6);
    drain_and_check();

    // R3: subtraction with extremes
    h = 4; mode = 1; apply_cfg(); do_reset(); cur_tag = "R3";
    for (int i = 0; i < 16; i++) send((i % 3 == 0) ? 32767 : -32768, 6);
    drain_and_check();

    // R11: back-to-back due samples while issuing
    load_coefs(0);
    h = 4; mode = 0; rate = 0; apply_cfg(); do_reset(); cur_tag = "R11";
    for (int i = 0; i < 10; i++) send(rnd_smp(), 8);
    check(overrun_o === 1'b0, "R11 no overrun when spaced", longint'(overrun_o), 0);
    for (int i = 0; i < 6; i++) send(rnd_smp(), 0);
    drain_and_check();

    // R8: disabled history still fills
    h = 3; odd = 1; mode = 0; rate = 1; en = 0; apply_cfg(); do_reset(); cur_tag = "R8 R5";
    for (int i = 0; i < 10; i++) send(rnd_smp(), 1);
    check(vld_seen == 0, "R8 no result while disabled", longint'(vld_seen), 0);
    en = 1; apply_cfg();
    for (int i = 0; i < 10; i++) send(rnd_smp(), 5);
    drain_and_check();

    // R9 + R12: coefficients kept through reset, feedback cut
    h = 5; odd = 0; mode = 2; rate = 0; clr = 1; en = 1; apply_cfg(); do_reset(); cur_tag = "R9 R12";
    for (int i = 0; i < 14; i++) send(rnd_smp(), 9);
    drain_and_check();

    // R6: decimation phase
    h = 2; mode = 0; rate = 2; clr = 0; apply_cfg(); do_reset(); cur_tag = "R6";
    for (int i = 0; i < 15; i++) send(rnd_smp(), 6);
    drain_and_check();

    // random configurations
    for (int r = 0; r < 14; r++) begin
      load_coefs(0);
      h = int'($urandom_range(1, 8)); odd = int'($urandom_range(0, 1));
      mode = int'($urandom_range(0, 3)); rate = int'($urandom_range(0, 3));
      clr = ($urandom_range(0, 4) == 0) ? 1 : 0; en = 1; apply_cfg(); do_reset();
      cur_tag = (clr != 0) ? "R9" : (mode == 1) ? "R3" : (mode >= 2) ? "R4" : (odd != 0) ? "R5" : "R2";
      for (int i = 0; i < 40; i++) begin
        if (i == 20 && $urandom_range(0, 1) == 1) begin en = 0; apply_cfg(); end
        if (i == 26) begin en = 1; apply_cfg(); end
        send(rnd_smp(), int'($urandom_range(0, h + 2)));
      end
      drain_and_check();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule